// File: doc/BRIEF.md
# Shift and Rotate Unit with Carry

This block moves the bits of a parameterised data word left or right by a count taken from a small count field. It offers eight operations: logical left and right shifts, arithmetic left and right shifts, rotations that wrap the word onto itself, and rotations that pass through a carry flag. A caller presents the operand, the incoming carry flag, an operation code and a count, then pulses a start strobe. The block returns the new word, the new carry flag and a one-cycle valid strobe.

The carry flag always keeps the last bit that left the word. For the two through-carry rotations the flag acts as one more bit in a ring of width+1 bits. A build parameter selects one of two engines. The unrolled engine finishes in one clock. The iterative engine moves one bit per clock and needs far less logic.

Top module: `shift_rotate_unit`

## Requirements
- R1: While reset is asserted, and after it is released until the first start, `valid_o` is 0, `result_o` is all zeros and `carry_o` is 0.
- R2: Operation codes 0 (logical left) and 3 (arithmetic left) behave identically. Bits move toward the MSB, zeros fill the vacated low bits, and `carry_o` holds the last bit that left the MSB end.
- R3: Operation code 1 (logical right) fills the vacated high bits with zeros, and `carry_o` holds the last bit that left the LSB end.
- R4: Operation code 2 (arithmetic right) fills the vacated high bits with copies of the operand's sign bit, and `carry_o` holds the last bit that left the LSB end.
- R5: Operation codes 4 (rotate left) and 5 (rotate right) wrap bits from one end of the word to the other. `carry_o` equals the last bit that wrapped, and the number of ones in the word is preserved.
- R6: Operation codes 6 (left through carry) and 7 (right through carry) rotate the ring {carry, word}. For a left rotation the MSB enters the carry and the old carry enters bit 0. For a right rotation bit 0 enters the carry and the old carry enters the MSB.
- R7: A count of zero returns the operand unchanged, and `carry_o` equals `carry_i`, for every operation.
- R8: For codes 0 to 3, a count equal to the width gives the fill value. For codes 0, 1 and 3 the fill value is zero, and the carry is the operand bit at the far end: bit 0 for left shifts, the MSB for the right shift. A larger count gives zero with carry 0. For code 2, any count of the width or more gives every bit equal to the sign bit, and the carry equals the sign bit.
- R9: For codes 4 and 5 the count is taken modulo the width. For codes 6 and 7 it is taken modulo width+1. A count that reduces to zero leaves both the word and the carry unchanged.
- R10: Each accepted start produces exactly one `valid_o` pulse of one cycle. In the unrolled build the pulse comes in the cycle after start. In the iterative build it comes reduced-count+2 cycles after the start edge. The reduced count is min(count, width+1) for codes 0 to 3, count mod width for codes 4 and 5, and count mod (width+1) for codes 6 and 7.
- R11: In the iterative build, a start that arrives while an operation is in flight is ignored and does not disturb that operation's result.
- R12: `result_o` and `carry_o` change only in cycles where `valid_o` is 1, and otherwise hold their last value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start_i | input | 1 | Start strobe that samples the operands |
| op_i | input | 3 | Operation code (see R2 to R6) |
| operand_i | input | WIDTH | Word to be shifted or rotated |
| count_i | input | CNT_W | Number of bit positions |
| carry_i | input | 1 | Incoming carry flag |
| result_o | output | WIDTH | Resulting word |
| carry_o | output | 1 | Resulting carry flag |
| valid_o | output | 1 | One-cycle strobe marking a new result |

## Verification
Two situations put two actions in the same cycle. In the first, a new start lands while the iterative engine is still stepping an earlier operation. The bench pulses a second start two cycles after a long shift. It then checks three things: the unrolled instance returns the second result at once, the iterative instance gives exactly one valid pulse, and that pulse carries the first operation's result. In the second, the unrolled engine accepts a start in the same cycle that it presents the previous result. The bench holds start for two cycles with different operands, checks both results on consecutive cycles, and then checks that the outputs hold once start falls.

// File: rtl/shr_pkg.sv
package shr_pkg;

  // Operation codes; the numeric values are part of the block's interface.
  typedef enum logic [2:0] {
    OP_SHL  = 3'd0,  // logical left
    OP_SHR  = 3'd1,  // logical right
    OP_SAR  = 3'd2,  // arithmetic right
    OP_SAL  = 3'd3,  // arithmetic left (same as logical left)
    OP_ROTL = 3'd4,  // rotate left, carry gets copy of wrapped bit
    OP_ROTR = 3'd5,  // rotate right, carry gets copy of wrapped bit
    OP_RLC  = 3'd6,  // rotate left through carry
    OP_RRC  = 3'd7   // rotate right through carry
  } shr_op_e;

  function automatic logic is_plain_rot(shr_op_e op);
    return (op == OP_ROTL) || (op == OP_ROTR);
  endfunction

  function automatic logic is_carry_rot(shr_op_e op);
    return (op == OP_RLC) || (op == OP_RRC);
  endfunction

endpackage

// File: rtl/shr_step.sv
// One-position move of the {carry, word} pair for any operation.
module shr_step
  import shr_pkg::*;
#(
  parameter int WIDTH = 16
) (
  input  shr_op_e          op_i,
  input  logic [WIDTH-1:0] word_i,
  input  logic             carry_i,
  output logic [WIDTH-1:0] word_o,
  output logic             carry_o
);

  localparam int MSB = WIDTH - 1;

  always_comb begin
    unique case (op_i)
      OP_SHL, OP_SAL: begin
        word_o  = {word_i[MSB-1:0], 1'b0};
        carry_o = word_i[MSB];
      end
      OP_SHR: begin
        word_o  = {1'b0, word_i[MSB:1]};
        carry_o = word_i[0];
      end
      OP_SAR: begin
        word_o  = {word_i[MSB], word_i[MSB:1]};
        carry_o = word_i[0];
      end
      OP_ROTL: begin
        word_o  = {word_i[MSB-1:0], word_i[MSB]};
        carry_o = word_i[MSB];
      end
      OP_ROTR: begin
        word_o  = {word_i[0], word_i[MSB:1]};
        carry_o = word_i[0];
      end
      OP_RLC: begin
        word_o  = {word_i[MSB-1:0], carry_i};
        carry_o = word_i[MSB];
      end
      default: begin  // OP_RRC
        word_o  = {carry_i, word_i[MSB:1]};
        carry_o = word_i[0];
      end
    endcase
  end

endmodule

// File: rtl/shr_count_norm.sv
// Reduces the raw count to the number of one-bit steps actually needed.
module shr_count_norm
  import shr_pkg::*;
#(
  parameter int WIDTH  = 16,
  parameter int CNT_W  = 5,
  parameter int STEP_W = $clog2(WIDTH + 2)
) (
  input  shr_op_e           op_i,
  input  logic [CNT_W-1:0]  count_i,
  output logic [STEP_W-1:0] steps_o
);

  localparam int RING = WIDTH + 1;

  always_comb begin
    automatic int raw = int'(count_i);
    automatic int red;
    if (is_carry_rot(op_i)) begin
      red = raw % RING;
    end else if (is_plain_rot(op_i)) begin
      red = raw % WIDTH;
    end else begin
      // Beyond width+1 steps a shift result no longer changes.
      red = (raw > RING) ? RING : raw;
    end
    steps_o = STEP_W'(red);
  end

endmodule

// File: rtl/shr_unrolled.sv
// Single-cycle engine: width+1 chained step stages, each bypassed past the count.
module shr_unrolled
  import shr_pkg::*;
#(
  parameter int WIDTH  = 16,
  parameter int STEP_W = $clog2(WIDTH + 2)
) (
  input  shr_op_e           op_i,
  input  logic [WIDTH-1:0]  word_i,
  input  logic              carry_i,
  input  logic [STEP_W-1:0] steps_i,
  output logic [WIDTH-1:0]  word_o,
  output logic              carry_o
);

  localparam int STAGES = WIDTH + 1;

  logic [WIDTH-1:0] w_s [STAGES+1];
  logic             c_s [STAGES+1];

  assign w_s[0] = word_i;
  assign c_s[0] = carry_i;

  for (genvar k = 0; k < STAGES; k++) begin : g_stage
    logic [WIDTH-1:0] st_w;
    logic             st_c;
    logic             take;

    shr_step #(.WIDTH(WIDTH)) u_step (
      .op_i   (op_i),
      .word_i (w_s[k]),
      .carry_i(c_s[k]),
      .word_o (st_w),
      .carry_o(st_c)
    );

    assign take       = STEP_W'(k) < steps_i;
    assign w_s[k + 1] = take ? st_w : w_s[k];
    assign c_s[k + 1] = take ? st_c : c_s[k];
  end

  assign word_o  = w_s[STAGES];
  assign carry_o = c_s[STAGES];

endmodule

// File: rtl/shr_iter.sv
// Iterative engine: one bit position per clock, result published on completion.
module shr_iter
  import shr_pkg::*;
#(
  parameter int WIDTH  = 16,
  parameter int STEP_W = $clog2(WIDTH + 2)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  shr_op_e           op_i,
  input  logic [WIDTH-1:0]  word_i,
  input  logic              carry_i,
  input  logic [STEP_W-1:0] steps_i,
  output logic [WIDTH-1:0]  word_o,
  output logic              carry_o,
  output logic              valid_o
);

  logic              busy_q,  busy_d;
  logic [STEP_W-1:0] rem_q,   rem_d;
  shr_op_e           op_q,    op_d;
  logic [WIDTH-1:0]  ring_w_q, ring_w_d;
  logic              ring_c_q, ring_c_d;
  logic [WIDTH-1:0]  res_w_q, res_w_d;
  logic              res_c_q, res_c_d;
  logic              valid_q, valid_d;
  logic [WIDTH-1:0]  st_w;
  logic              st_c;

  shr_step #(.WIDTH(WIDTH)) u_step (
    .op_i   (op_q),
    .word_i (ring_w_q),
    .carry_i(ring_c_q),
    .word_o (st_w),
    .carry_o(st_c)
  );

  // next-state
  always_comb begin
    busy_d   = busy_q;
    rem_d    = rem_q;
    op_d     = op_q;
    ring_w_d = ring_w_q;
    ring_c_d = ring_c_q;
    res_w_d  = res_w_q;
    res_c_d  = res_c_q;
    valid_d  = 1'b0;
    if (busy_q) begin
      if (rem_q == '0) begin
        busy_d  = 1'b0;
        valid_d = 1'b1;
        res_w_d = ring_w_q;
        res_c_d = ring_c_q;
      end else begin
        ring_w_d = st_w;
        ring_c_d = st_c;
        rem_d    = rem_q - 1'b1;
      end
    end else if (start_i) begin
      busy_d   = 1'b1;
      rem_d    = steps_i;
      op_d     = op_i;
      ring_w_d = word_i;
      ring_c_d = carry_i;
    end
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q   <= 1'b0;
      rem_q    <= '0;
      op_q     <= OP_SHL;
      ring_w_q <= '0;
      ring_c_q <= 1'b0;
      res_w_q  <= '0;
      res_c_q  <= 1'b0;
      valid_q  <= 1'b0;
    end else begin
      busy_q   <= busy_d;
      rem_q    <= rem_d;
      op_q     <= op_d;
      ring_w_q <= ring_w_d;
      ring_c_q <= ring_c_d;
      res_w_q  <= res_w_d;
      res_c_q  <= res_c_d;
      valid_q  <= valid_d;
    end
  end

  assign word_o  = res_w_q;
  assign carry_o = res_c_q;
  assign valid_o = valid_q;

  // R10: one step per clock while work remains
  assert_step_countdown_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && rem_q != '0) |=> (rem_q == $past(rem_q) - 1'b1));

  // R10: the strobe marks the end of an operation, never mid-flight
  assert_valid_after_busy_R10: assert property (@(posedge clk) disable iff (!rst_n)
    valid_q |-> (!busy_q && $past(busy_q)));

  // R11: a start during an operation does not reload the operation
  assert_busy_start_ignored_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && rem_q != '0 && start_i) |=> (busy_q && op_q == $past(op_q)));

  // R5: a plain rotation step preserves the population of the word
  assert_rot_ones_kept_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && rem_q != '0 && is_plain_rot(op_q))
      |=> ($countones(ring_w_q) == $countones($past(ring_w_q))));

endmodule

// File: rtl/shift_rotate_unit.sv
module shift_rotate_unit
  import shr_pkg::*;
#(
  parameter int WIDTH     = 16,
  parameter int CNT_W     = 5,
  parameter bit ITERATIVE = 1'b0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic [2:0]       op_i,
  input  logic [WIDTH-1:0] operand_i,
  input  logic [CNT_W-1:0] count_i,
  input  logic             carry_i,
  output logic [WIDTH-1:0] result_o,
  output logic             carry_o,
  output logic             valid_o
);

  localparam int STEP_W = $clog2(WIDTH + 2);

  // reset: asserted asynchronously, released on a clock edge
  logic [1:0] rst_sync_q;
  logic       rst_n_int;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n_int = rst_sync_q[1];

  shr_op_e           op_e;
  logic [STEP_W-1:0] steps;

  assign op_e = shr_op_e'(op_i);

  shr_count_norm #(.WIDTH(WIDTH), .CNT_W(CNT_W), .STEP_W(STEP_W)) u_norm (
    .op_i   (op_e),
    .count_i(count_i),
    .steps_o(steps)
  );

  if (ITERATIVE) begin : g_iter

    shr_iter #(.WIDTH(WIDTH), .STEP_W(STEP_W)) u_iter (
      .clk    (clk),
      .rst_n  (rst_n_int),
      .start_i(start_i),
      .op_i   (op_e),
      .word_i (operand_i),
      .carry_i(carry_i),
      .steps_i(steps),
      .word_o (result_o),
      .carry_o(carry_o),
      .valid_o(valid_o)
    );

  end else begin : g_flat

    logic [WIDTH-1:0] comb_w;
    logic             comb_c;
    logic [WIDTH-1:0] res_w_q, res_w_d;
    logic             res_c_q, res_c_d;
    logic             valid_q;
    logic             load_en;

    shr_unrolled #(.WIDTH(WIDTH), .STEP_W(STEP_W)) u_flat (
      .op_i   (op_e),
      .word_i (operand_i),
      .carry_i(carry_i),
      .steps_i(steps),
      .word_o (comb_w),
      .carry_o(comb_c)
    );

    assign load_en = start_i;

    always_comb begin
      res_w_d = res_w_q;
      res_c_d = res_c_q;
      if (load_en) begin
        res_w_d = comb_w;
        res_c_d = comb_c;
      end
    end

    always_ff @(posedge clk or negedge rst_n_int) begin
      if (!rst_n_int) begin
        res_w_q <= '0;
        res_c_q <= 1'b0;
        valid_q <= 1'b0;
      end else begin
        res_w_q <= res_w_d;
        res_c_q <= res_c_d;
        valid_q <= load_en;
      end
    end

    assign result_o = res_w_q;
    assign carry_o  = res_c_q;
    assign valid_o  = valid_q;

    // R10: one strobe, in the cycle after each start
    assert_valid_after_start_R10: assert property (@(posedge clk) disable iff (!rst_n_int)
      start_i |=> valid_o);

    // R5: plain rotation keeps the count of ones
    assert_rot_ones_kept_R5: assert property (@(posedge clk) disable iff (!rst_n_int)
      (start_i && is_plain_rot(op_e))
        |=> ($countones(result_o) == $countones($past(operand_i))));

    // R6: rotation through carry keeps the ones of the whole ring
    assert_ring_ones_kept_R6: assert property (@(posedge clk) disable iff (!rst_n_int)
      (start_i && is_carry_rot(op_e))
        |=> ($countones({carry_o, result_o}) == $countones({$past(carry_i), $past(operand_i)})));

    // R7: count zero passes word and carry through
    assert_zero_count_identity_R7: assert property (@(posedge clk) disable iff (!rst_n_int)
      (start_i && count_i == '0)
        |=> (result_o == $past(operand_i) && carry_o == $past(carry_i)));

  end

  // R12: outputs hold between strobes
  assert_hold_between_strobes_R12: assert property (@(posedge clk) disable iff (!rst_n_int)
    !valid_o |-> ($stable(result_o) && $stable(carry_o)));

endmodule

// File: tb/sim_shift_rotate_unit.sv
`timescale 1ns/1ps
module sim_shift_rotate_unit;

  localparam int W  = 8;
  localparam int CW = 4;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          start;
  logic [2:0]    op;
  logic [W-1:0]  opnd;
  logic          cin;
  logic [CW-1:0] cnt;
  logic [W-1:0]  r0, r1;
  logic          c0, c1, v0, v1;

  int checks   = 0;
  int failures = 0;
  bit done     = 0;

  always #10 clk = ~clk;  // 50 MHz

  shift_rotate_unit #(.WIDTH(W), .CNT_W(CW), .ITERATIVE(1'b0)) u0 (
    .clk(clk), .rst_n(rst_n), .start_i(start), .op_i(op), .operand_i(opnd),
    .count_i(cnt), .carry_i(cin), .result_o(r0), .carry_o(c0), .valid_o(v0));

  shift_rotate_unit #(.WIDTH(W), .CNT_W(CW), .ITERATIVE(1'b1)) u1 (
    .clk(clk), .rst_n(rst_n), .start_i(start), .op_i(op), .operand_i(opnd),
    .count_i(cnt), .carry_i(cin), .result_o(r1), .carry_o(c1), .valid_o(v1));

  // {req[3:0], op[2:0], operand[7:0], cin, count[3:0], result[7:0], cout}
  localparam int NV = 30;
  localparam logic [28:0] VEC [NV] = '{
    {4'd2, 3'd0, 8'hB3, 1'b0, 4'd1,  8'h66, 1'b1},  // R2 shift left
    {4'd2, 3'd0, 8'hB3, 1'b1, 4'd2,  8'hCC, 1'b0},  // R2 carry replaced
    {4'd2, 3'd3, 8'hB3, 1'b0, 4'd1,  8'h66, 1'b1},  // R2 arith left
    {4'd2, 3'd3, 8'hB3, 1'b1, 4'd2,  8'hCC, 1'b0},  // R2
    {4'd3, 3'd1, 8'hB3, 1'b0, 4'd2,  8'h2C, 1'b1},  // R3 shift right
    {4'd3, 3'd1, 8'h80, 1'b1, 4'd1,  8'h40, 1'b0},  // R3
    {4'd4, 3'd2, 8'h96, 1'b0, 4'd3,  8'hF2, 1'b1},  // R4 negative
    {4'd4, 3'd2, 8'h74, 1'b1, 4'd2,  8'h1D, 1'b0},  // R4 positive
    {4'd5, 3'd4, 8'hB3, 1'b0, 4'd2,  8'hCE, 1'b0},  // R5 rotate left
    {4'd5, 3'd4, 8'h81, 1'b0, 4'd1,  8'h03, 1'b1},  // R5
    {4'd5, 3'd5, 8'hB3, 1'b0, 4'd1,  8'hD9, 1'b1},  // R5 rotate right
    {4'd5, 3'd5, 8'hB3, 1'b1, 4'd3,  8'h76, 1'b0},  // R5
    {4'd6, 3'd6, 8'hB3, 1'b0, 4'd1,  8'h66, 1'b1},  // R6 left thru carry
    {4'd6, 3'd6, 8'hB3, 1'b1, 4'd2,  8'hCF, 1'b0},  // R6
    {4'd6, 3'd7, 8'hB3, 1'b1, 4'd1,  8'hD9, 1'b1},  // R6 right thru carry
    {4'd6, 3'd7, 8'hB3, 1'b0, 4'd1,  8'h59, 1'b1},  // R6
    {4'd7, 3'd1, 8'hB3, 1'b1, 4'd0,  8'hB3, 1'b1},  // R7 zero count
    {4'd7, 3'd7, 8'h5A, 1'b0, 4'd0,  8'h5A, 1'b0},  // R7
    {4'd8, 3'd0, 8'hFF, 1'b0, 4'd8,  8'h00, 1'b1},  // R8 count = width
    {4'd8, 3'd3, 8'hFF, 1'b0, 4'd8,  8'h00, 1'b1},  // R8
    {4'd8, 3'd0, 8'hFF, 1'b1, 4'd9,  8'h00, 1'b0},  // R8 count > width
    {4'd8, 3'd1, 8'h80, 1'b0, 4'd8,  8'h00, 1'b1},  // R8
    {4'd8, 3'd2, 8'h80, 1'b0, 4'd12, 8'hFF, 1'b1},  // R8 sign fill
    {4'd8, 3'd2, 8'h40, 1'b1, 4'd15, 8'h00, 1'b0},  // R8
    {4'd9, 3'd4, 8'hB3, 1'b1, 4'd8,  8'hB3, 1'b1},  // R9 mod width -> 0
    {4'd9, 3'd4, 8'hB3, 1'b0, 4'd10, 8'hCE, 1'b0},  // R9 10 mod 8 = 2
    {4'd9, 3'd5, 8'hB3, 1'b0, 4'd9,  8'hD9, 1'b1},  // R9 9 mod 8 = 1
    {4'd9, 3'd6, 8'hB3, 1'b0, 4'd10, 8'h66, 1'b1},  // R9 10 mod 9 = 1
    {4'd9, 3'd7, 8'h01, 1'b0, 4'd9,  8'h01, 1'b0},  // R9 9 mod 9 = 0
    {4'd9, 3'd6, 8'hB3, 1'b1, 4'd9,  8'hB3, 1'b1}   // R9
  };

  task automatic chk(input string req, input string what,
                     input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // reduced step count, from R10
  function automatic int exp_steps(logic [2:0] o, int n);
    if (o >= 3'd6) return n % (W + 1);
    if (o >= 3'd4) return n % W;
    return (n > W + 1) ? W + 1 : n;
  endfunction

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; start = 1'b0; op = '0; opnd = '0; cin = 1'b0; cnt = '0;
    idle(3);
    // R1 during reset
    chk("R1", "u0 valid in reset", 16'(v0), 16'h0);
    chk("R1", "u1 valid in reset", 16'(v1), 16'h0);
    rst_n = 1'b1;
    idle(4);
    // R1 after release
    chk("R1", "u0 result", 16'(r0), 16'h0);
    chk("R1", "u0 carry", 16'(c0), 16'h0);
    chk("R1", "u1 result", 16'(r1), 16'h0);
    chk("R1", "u1 carry", 16'(c1), 16'h0);
    chk("R1", "u0 valid", 16'(v0), 16'h0);

    // table walk: both engines, result, carry and latency (R10)
    for (int i = 0; i < NV; i++) begin
      logic [28:0] v;
      string       rq;
      int          t0, t1, pulses1;
      logic [W-1:0] g0, g1;
      logic        gc0, gc1;
      v  = VEC[i];
      rq = $sformatf("R%0d", v[28:25]);
      t0 = -1; t1 = -1; pulses1 = 0;
      g0 = '0; g1 = '0; gc0 = 1'b0; gc1 = 1'b0;
      op = v[24:22]; opnd = v[21:14]; cin = v[13]; cnt = v[12:9];
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      for (int t = 0; t < 16; t++) begin
        if (v0 && t0 < 0) begin t0 = t; g0 = r0; gc0 = c0; end
        if (v1) begin
          pulses1++;
          if (t1 < 0) begin t1 = t; g1 = r1; gc1 = c1; end
        end
        @(negedge clk);
      end
      chk(rq, $sformatf("vec%0d u0 result", i), 16'(g0), 16'(v[8:1]));
      chk(rq, $sformatf("vec%0d u0 carry", i), 16'(gc0), 16'(v[0]));
      chk(rq, $sformatf("vec%0d u1 result", i), 16'(g1), 16'(v[8:1]));
      chk(rq, $sformatf("vec%0d u1 carry", i), 16'(gc1), 16'(v[0]));
      chk("R10", $sformatf("vec%0d u0 latency", i), 16'(t0), 16'h0);
      chk("R10", $sformatf("vec%0d u1 latency", i), 16'(t1),
          16'(exp_steps(v[24:22], int'(v[12:9])) + 1));
      chk("R10", $sformatf("vec%0d u1 pulses", i), 16'(pulses1), 16'h1);
    end

    // R11: second start while the iterative engine is busy
    begin
      int pulses; logic [W-1:0] g; logic gc;
      pulses = 0; g = '1; gc = 1'b0;
      op = 3'd0; opnd = 8'hFF; cin = 1'b0; cnt = 4'd8; start = 1'b1;
      @(negedge clk);  // N1
      start = 1'b0;
      chk("R8", "u0 long shift result", 16'(r0), 16'h00);
      @(negedge clk);  // N2
      op = 3'd4; opnd = 8'h0F; cin = 1'b0; cnt = 4'd1; start = 1'b1;
      @(negedge clk);  // N3
      start = 1'b0;
      chk("R11", "u0 takes second start", 16'(r0), 16'h1E);
      chk("R11", "u0 second carry", 16'(c0), 16'h0);
      for (int t = 0; t < 14; t++) begin
        if (v1) begin pulses++; g = r1; gc = c1; end
        @(negedge clk);
      end
      chk("R11", "u1 pulse count", 16'(pulses), 16'h1);
      chk("R11", "u1 keeps first result", 16'(g), 16'h00);
      chk("R11", "u1 keeps first carry", 16'(gc), 16'h1);
    end

    idle(4);
    // back-to-back starts on the unrolled engine, then hold (R10, R12)
    op = 3'd5; opnd = 8'h01; cin = 1'b0; cnt = 4'd1; start = 1'b1;
    @(negedge clk);
    chk("R10", "b2b first valid", 16'(v0), 16'h1);
    chk("R5", "b2b first result", 16'(r0), 16'h80);
    chk("R5", "b2b first carry", 16'(c0), 16'h1);
    op = 3'd2; opnd = 8'hC4; cin = 1'b1; cnt = 4'd2;
    @(negedge clk);
    start = 1'b0;
    chk("R10", "b2b second valid", 16'(v0), 16'h1);
    chk("R4", "b2b second result", 16'(r0), 16'hF1);
    chk("R4", "b2b second carry", 16'(c0), 16'h0);
    opnd = 8'h3C; cin = 1'b1;
    @(negedge clk);
    chk("R10", "valid drops", 16'(v0), 16'h0);
    chk("R12", "result holds", 16'(r0), 16'hF1);
    chk("R12", "carry holds", 16'(c0), 16'h0);
    idle(3);
    chk("R11", "u1 result of first b2b", 16'(r1), 16'h80);
    chk("R12", "u1 carry held", 16'(c1), 16'h1);
    chk("R12", "u1 valid idle", 16'(v1), 16'h0);

    idle(2);
    finish_run();
  end

endmodule